// File: doc/BRIEF.md
# Masked-Wrap Burst Address Counter

This block generates the address for one port of a synchronous dual-port RAM. An external address is loaded into an internal counter. The counter then steps through consecutive addresses on each clock where stepping is requested, so no new address has to be supplied. A programmable mask chooses which low-order bits count. The bits above the mask keep their loaded value. The mask therefore sets the size and alignment of the block the counter sweeps.

When the counted bits roll over, an active-low wrap flag drops and stays low until the next load or reset. A retransmit command puts the counter back to the address it was last loaded with, so the same block can be read again. Two readback commands present either the counter value or the mask value on a registered readback bus, with a valid strobe. All controls take effect at the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: Asynchronous reset (rst_ni low) and synchronous reset (srst_i high at an edge) set the counter and the stored start address to zero and the mask to all ones, and raise wrap_n_o. srst_i overrides every other control.
- R2: load_i stores addr_i into the counter and the start address at the edge, and raises wrap_n_o. It takes priority over mask load, retransmit and increment.
- R3: inc_i adds one to the masked (low) counter bits. Bits outside the mask keep their value.
- R4: An increment when all masked bits are one clears those bits and drives wrap_n_o low after the edge. With a zero mask, every increment wraps and leaves the counter unchanged.
- R5: Once wrap_n_o is low, it stays low until a load or a reset.
- R6: mask_ld_i writes addr_i to the mask only when the value is a run of ones from bit 0 ((v & (v+1)) == 0). Any other value is ignored and the old mask is kept. Mask load leaves the counter unchanged and takes priority over retransmit and increment.
- R7: rexmit_i returns the counter to the stored start address and takes priority over increment.
- R8: After an edge with cnt_rb_i high, rb_o holds the counter value from before that edge and rb_vld_o is high. With mask_rb_i high, rb_o holds the mask from before that edge, and the mask wins when both are high. With neither high, rb_vld_o is low and rb_o is zero.
- R9: The readback commands do not change the counter or the mask. An increment, load, mask load or retransmit in the same cycle takes effect as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| srst_i | input | 1 | Synchronous reset |
| addr_i | input | ADDR_W | External address / mask value |
| load_i | input | 1 | Load counter and start address |
| inc_i | input | 1 | Step the counter |
| rexmit_i | input | 1 | Return to start address |
| mask_ld_i | input | 1 | Write mask register |
| cnt_rb_i | input | 1 | Read back counter |
| mask_rb_i | input | 1 | Read back mask |
| addr_o | output | ADDR_W | Current counter address |
| wrap_n_o | output | 1 | Wrap flag, active low, sticky |
| rb_o | output | ADDR_W | Registered readback data |
| rb_vld_o | output | 1 | Readback data valid |

## Verification
A readback and a counter operation can fall in the same edge. Examples are a counter readback together with an increment, and a mask readback together with a mask write. The bench drives both commands in one cycle. It expects the readback bus to show the value from before the edge, and the counter or mask to move as it would without the readback. The bench also drives pairs of counter controls in one cycle and checks that only the highest-priority one acts.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_RESET  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_MASK   = 3'd3,
    OP_REXMIT = 3'd4,
    OP_INC    = 3'd5
  } burst_op_e;

  typedef enum logic [1:0] {
    RB_NONE = 2'd0,
    RB_CNT  = 2'd1,
    RB_MASK = 2'd2
  } rb_sel_e;
endpackage

// File: rtl/burst_op_dec.sv
`timescale 1ns/1ps
module burst_op_dec
  import burst_pkg::*;
(
  input  logic      srst_i,
  input  logic      load_i,
  input  logic      mask_ld_i,
  input  logic      rexmit_i,
  input  logic      inc_i,
  input  logic      cnt_rb_i,
  input  logic      mask_rb_i,
  output burst_op_e op_o,
  output rb_sel_e   rb_sel_o
);
  // fixed priority: reset > load > mask > retransmit > increment
  always_comb begin
    if (srst_i)         op_o = OP_RESET;
    else if (load_i)    op_o = OP_LOAD;
    else if (mask_ld_i) op_o = OP_MASK;
    else if (rexmit_i)  op_o = OP_REXMIT;
    else if (inc_i)     op_o = OP_INC;
    else                op_o = OP_HOLD;
  end

  always_comb begin
    if (mask_rb_i)     rb_sel_o = RB_MASK;
    else if (cnt_rb_i) rb_sel_o = RB_CNT;
    else               rb_sel_o = RB_NONE;
  end
endmodule

// File: rtl/burst_mask_reg.sv
`timescale 1ns/1ps
module burst_mask_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_op_e         op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] MASK_RST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] mask_q;
  logic              contig;

  assign contig = ((addr_i & (addr_i + 1'b1)) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mask_q <= MASK_RST;
    else if (op_i == OP_RESET)        mask_q <= MASK_RST;
    else if (op_i == OP_MASK && contig) mask_q <= addr_i;
  end

  assign mask_o = mask_q;

  AST_MASK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MASK && !contig) |=> $stable(mask_o)); // R6
  AST_MASK_SRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESET) |=> (mask_o == MASK_RST)); // R1
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_RESET && op_i != OP_MASK) |=> $stable(mask_o)); // R9
endmodule

// File: rtl/burst_counter.sv
`timescale 1ns/1ps
module burst_counter
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  burst_op_e         op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              wrap_n_o
);
  logic [ADDR_W-1:0] cnt_q, start_q, cnt_step;
  logic              wrap_n_q, at_top;

  // masked bits are low-order, so +1 never carries past the mask unless at_top
  assign at_top   = ((cnt_q & mask_i) == mask_i);
  assign cnt_step = (cnt_q & ~mask_i) | (at_top ? '0 : ((cnt_q + 1'b1) & mask_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      start_q  <= '0;
      wrap_n_q <= 1'b1;
    end else begin
      unique case (op_i)
        OP_RESET: begin
          cnt_q    <= '0;
          start_q  <= '0;
          wrap_n_q <= 1'b1;
        end
        OP_LOAD: begin
          cnt_q    <= addr_i;
          start_q  <= addr_i;
          wrap_n_q <= 1'b1;
        end
        OP_REXMIT: cnt_q <= start_q;
        OP_INC: begin
          cnt_q <= cnt_step;
          if (at_top) wrap_n_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign wrap_n_o = wrap_n_q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (cnt_o == $past(addr_i) && wrap_n_o)); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC) |=> ((cnt_o & ~$past(mask_i)) == ($past(cnt_o) & ~$past(mask_i)))); // R3
  AST_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INC && (cnt_o & mask_i) == mask_i) |=> !wrap_n_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_n_o && op_i != OP_LOAD && op_i != OP_RESET) |=> !wrap_n_o); // R5
  AST_REXMIT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_REXMIT) |=> (cnt_o == $past(start_q))); // R7
  AST_MASK_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MASK) |=> $stable(cnt_o)); // R6
endmodule

// File: rtl/burst_readback.sv
`timescale 1ns/1ps
module burst_readback
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rb_sel_e           sel_i,
  input  logic [ADDR_W-1:0] cnt_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] rb_o,
  output logic              rb_vld_o
);
  logic [ADDR_W-1:0] rb_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= (sel_i != RB_NONE);
      unique case (sel_i)
        RB_MASK: rb_q <= mask_i;
        RB_CNT:  rb_q <= cnt_i;
        default: rb_q <= '0;
      endcase
    end
  end

  assign rb_o     = rb_q;
  assign rb_vld_o = vld_q;

  AST_RB_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == RB_CNT) |=> (rb_vld_o && rb_o == $past(cnt_i))); // R8
  AST_RB_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == RB_MASK) |=> (rb_vld_o && rb_o == $past(mask_i))); // R8
  AST_RB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == RB_NONE) |=> (!rb_vld_o && rb_o == '0)); // R8
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic              rexmit_i,
  input  logic              mask_ld_i,
  input  logic              cnt_rb_i,
  input  logic              mask_rb_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_n_o,
  output logic [ADDR_W-1:0] rb_o,
  output logic              rb_vld_o
);
  burst_op_e         op;
  rb_sel_e           rb_sel;
  logic [ADDR_W-1:0] mask, cnt;

  burst_op_dec u_dec (
    .srst_i   (srst_i),
    .load_i   (load_i),
    .mask_ld_i(mask_ld_i),
    .rexmit_i (rexmit_i),
    .inc_i    (inc_i),
    .cnt_rb_i (cnt_rb_i),
    .mask_rb_i(mask_rb_i),
    .op_o     (op),
    .rb_sel_o (rb_sel)
  );

  burst_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .addr_i(addr_i),
    .mask_o(mask)
  );

  burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .addr_i  (addr_i),
    .mask_i  (mask),
    .cnt_o   (cnt),
    .wrap_n_o(wrap_n_o)
  );

  burst_readback #(.ADDR_W(ADDR_W)) u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (rb_sel),
    .cnt_i   (cnt),
    .mask_i  (mask),
    .rb_o    (rb_o),
    .rb_vld_o(rb_vld_o)
  );

  assign addr_o = cnt;

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (addr_o == '0 && wrap_n_o)); // R1
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 8;
  // op bits: {srst, load, mask_ld, rexmit, inc, cnt_rb, mask_rb}
  localparam logic [6:0] NOP = 7'b0000000, SR = 7'b1000000, LD = 7'b0100000,
                         ML = 7'b0010000, RX = 7'b0001000, IN = 7'b0000100,
                         CR = 7'b0000010, MR = 7'b0000001;
  localparam int NV = 26;
  // {ops, addr, expected counter after edge, expected wrap_n}
  localparam logic [23:0] VEC [0:NV-1] = '{
    {LD,      8'h3C, 8'h3C, 1'b1}, // R2
    {ML,      8'h03, 8'h3C, 1'b1}, // R6
    {IN,      8'h00, 8'h3D, 1'b1}, // R3
    {IN,      8'h00, 8'h3E, 1'b1}, // R3
    {IN,      8'h00, 8'h3F, 1'b1}, // R3
    {IN,      8'h00, 8'h3C, 1'b0}, // R4
    {IN,      8'h00, 8'h3D, 1'b0}, // R5
    {RX,      8'h00, 8'h3C, 1'b0}, // R7 R5
    {LD,      8'h5A, 8'h5A, 1'b1}, // R2 R5
    {ML,      8'h05, 8'h5A, 1'b1}, // R6 rejected
    {IN,      8'h00, 8'h5B, 1'b1}, // R6 old mask still 03
    {IN,      8'h00, 8'h58, 1'b0}, // R4
    {LD|IN,   8'h10, 8'h10, 1'b1}, // R2 priority
    {ML|IN,   8'h0F, 8'h10, 1'b1}, // R6 priority
    {RX|IN,   8'h00, 8'h10, 1'b1}, // R7 priority
    {IN,      8'h00, 8'h11, 1'b1}, // R3
    {RX|ML,   8'h07, 8'h11, 1'b1}, // R6 over R7
    {RX,      8'h00, 8'h10, 1'b1}, // R7
    {SR|LD,   8'h44, 8'h00, 1'b1}, // R1
    {IN,      8'h00, 8'h01, 1'b1}, // R1 mask back to FF
    {LD,      8'hFE, 8'hFE, 1'b1}, // R2
    {IN,      8'h00, 8'hFF, 1'b1}, // R3
    {IN,      8'h00, 8'h00, 1'b0}, // R4 full-width wrap
    {LD,      8'h77, 8'h77, 1'b1}, // R2
    {ML,      8'h00, 8'h77, 1'b1}, // R6 zero mask accepted
    {IN,      8'h00, 8'h77, 1'b0}  // R4 zero mask
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [6:0]    ops = '0;
  logic [AW-1:0] a = '0;
  logic [AW-1:0] addr_o, rb_o;
  logic          wrap_n, rb_vld;
  int            checks = 0, fails = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .srst_i   (ops[6]),
    .addr_i   (a),
    .load_i   (ops[5]),
    .mask_ld_i(ops[4]),
    .rexmit_i (ops[3]),
    .inc_i    (ops[2]),
    .cnt_rb_i (ops[1]),
    .mask_rb_i(ops[0]),
    .addr_o   (addr_o),
    .wrap_n_o (wrap_n),
    .rb_o     (rb_o),
    .rb_vld_o (rb_vld)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, then wait one full cycle
  task automatic step(input logic [6:0] o, input logic [AW-1:0] v);
    ops = o;
    a   = v;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL R1 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset addr", addr_o, 8'h00);
    chk("R1 reset wrap_n", {7'd0, wrap_n}, 8'h01);
    chk("R1 reset rb_vld", {7'd0, rb_vld}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    step(MR, 8'h00);
    chk("R1 reset mask", rb_o, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:17], VEC[i][16:9]);
      checks++;
      if (addr_o !== VEC[i][8:1] || wrap_n !== VEC[i][0]) begin
        fails++;
        $display("FAIL vector %0d (R1/R2/R3/R4/R5/R6/R7): actual %h/%b expected %h/%b",
                 i, addr_o, wrap_n, VEC[i][8:1], VEC[i][0]);
      end
    end

    // R1 asynchronous reset in mid-run while wrap flag is low
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async addr", addr_o, 8'h00);
    chk("R1 async wrap_n", {7'd0, wrap_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 readback, R9 overlap with counter operations
    step(LD, 8'h2B);
    step(ML, 8'h1F);
    step(CR, 8'h00);
    chk("R8 counter readback", rb_o, 8'h2B);
    chk("R8 counter readback valid", {7'd0, rb_vld}, 8'h01);
    chk("R9 counter after readback", addr_o, 8'h2B);
    step(MR, 8'h00);
    chk("R8 mask readback", rb_o, 8'h1F);
    step(CR | MR, 8'h00);
    chk("R8 both readbacks mask wins", rb_o, 8'h1F);
    step(NOP, 8'h00);
    chk("R8 idle valid low", {7'd0, rb_vld}, 8'h00);
    chk("R8 idle data zero", rb_o, 8'h00);
    step(CR | IN, 8'h00);
    chk("R9 readback shows pre-step count", rb_o, 8'h2B);
    chk("R9 increment still applied", addr_o, 8'h2C);
    step(MR | ML, 8'h0F);
    chk("R9 mask readback shows old mask", rb_o, 8'h1F);
    step(MR, 8'h00);
    chk("R9 mask write applied", rb_o, 8'h0F);
    step(CR | RX, 8'h00);
    chk("R9 readback before retransmit", rb_o, 8'h2C);
    chk("R9 retransmit applied", addr_o, 8'h2B);
    step(NOP, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule